// File: doc/BRIEF.md
# Channel Request and Watchdog Controller

This block governs ownership of a data channel that serves one device at a time. When the channel is idle, a one-cycle request strobe claims it for the requesting device. The claim latches the device number and sends a one-cycle initialisation pulse. That pulse tells the transfer engine to zero its bank and word-count registers and its rollover flag, and tells the sequencer to begin fetching the first program word. The same strobe, arriving while the channel is owned, ends the program. The current program counter is handed out for write-back to the device's program-pointer word in memory, and the channel returns to idle.

Two timers guard against a device that has gone quiet. A service-request watchdog runs whenever the sequencer is waiting for the device. If it expires, the transfer is aborted with an error pulse and the channel is freed. An acknowledge timer runs while a channel strobe is outstanding. If the device does not acknowledge in time, the program is terminated normally, with a pointer write-back and no error. The idle/enable output tells device interfaces whether a new start is allowed.

Top module: `chan_ctl`

## Requirements
- R1: While reset is held and immediately after it, sio_enable is 1, init_xfer, pp_wr and xfer_err are 0, and rollover_clr is 1 throughout reset; dev_num and pp_data are not cleared by reset.
- R2: A req sampled while sio_enable is 1 makes sio_enable 0 after that clock edge and raises init_xfer and rollover_clr for exactly one cycle.
- R3: On a claim, dev_num takes the value of sr_dev, the device-number field of the request bus (the bus carries the number shifted left by two). dev_num keeps that value until the next claim, whatever sr_dev does in between.
- R4: A req sampled while sio_enable is 0 makes sio_enable 1 after that edge and pulses pp_wr for one cycle. During that cycle pp_addr equals dev_num shifted left by two and zero-extended, and pp_data equals pc_in as sampled at that edge. init_xfer and xfer_err stay 0.
- R5: After WD_CYC consecutive clock edges at which the channel is busy, wait_sr is 1 and chansr is 0, the channel goes idle and xfer_err pulses for one cycle, with no pp_wr. One edge fewer leaves the channel busy.
- R6: A chansr sampled while waiting restarts the watchdog, so a full WD_CYC further waiting edges are needed before expiry.
- R7: The watchdog counts only while busy with wait_sr at 1. An edge with wait_sr at 0 clears it, and a busy channel with wait_sr at 0 stays busy indefinitely.
- R8: After ACK_CYC consecutive edges at which the channel is busy, chanso is 1 and chanack is 0, the channel goes idle with a pp_wr pulse carrying pc_in and no xfer_err.
- R9: A chanack (or chanso falling) restarts the acknowledge timer.
- R10: A req arriving at the same edge at which the watchdog would expire wins: the outcome is a pp_wr pulse with xfer_err at 0. An acknowledge expiry also wins over a coincident watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle start/abort strobe from a device interface |
| sr_dev | input | DEV_W | Device-number field of the service-request bus |
| chansr | input | 1 | Service request from the owning device |
| wait_sr | input | 1 | Sequencer is waiting for a device service request |
| chanso | input | 1 | Channel strobe to the device is outstanding |
| chanack | input | 1 | Device acknowledge of the channel strobe |
| pc_in | input | AW | Current program counter from the sequencer |
| sio_enable | output | 1 | High only while the channel is idle |
| init_xfer | output | 1 | One-cycle pulse: clear bank and word count, start fetch |
| rollover_clr | output | 1 | Clears the transfer rollover flag (claim or reset) |
| dev_num | output | DEV_W | Device number of the owning interface |
| pp_wr | output | 1 | One-cycle program-pointer write-back strobe |
| pp_addr | output | AW | Program-pointer word address (device number times four) |
| pp_data | output | AW | Program counter value to write back |
| xfer_err | output | 1 | One-cycle transfer-error pulse on watchdog abort |

## Verification
The bench builds the block with WD_CYC set to 20 and ACK_CYC set to 6, in place of the roughly 5715 and 58 cycles that a 175 ns clock would need. At these values every expiry, off-by-one edge and restart of both timers can be reached in a few dozen cycles. Each timer is driven to one edge short of expiry and then to the exact expiry edge. Restarts are placed one edge before expiry, and a request is made to coincide with a watchdog expiry.

// File: rtl/chan_ctl.sv
module chan_ctl #(
  parameter int DEV_W   = 8,
  parameter int AW      = 16,
  parameter int WD_CYC  = 5715,
  parameter int ACK_CYC = 58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [DEV_W-1:0]  sr_dev,
  input  logic              chansr,
  input  logic              wait_sr,
  input  logic              chanso,
  input  logic              chanack,
  input  logic [AW-1:0]     pc_in,
  output logic              sio_enable,
  output logic              init_xfer,
  output logic              rollover_clr,
  output logic [DEV_W-1:0]  dev_num,
  output logic              pp_wr,
  output logic [AW-1:0]     pp_addr,
  output logic [AW-1:0]     pp_data,
  output logic              xfer_err
);
  localparam int WD_W  = $clog2(WD_CYC + 1);
  localparam int ACK_W = $clog2(ACK_CYC + 1);
  localparam int PAD_W = AW - DEV_W - 2;

  logic             busy;
  logic [WD_W-1:0]  wd_cnt;
  logic [ACK_W-1:0] ack_cnt;

  wire wd_run  = busy & wait_sr & ~chansr;
  wire wd_hit  = wd_run && (wd_cnt == WD_W'(WD_CYC - 1));
  wire ack_run = busy & chanso & ~chanack;
  wire ack_hit = ack_run && (ack_cnt == ACK_W'(ACK_CYC - 1));

  assign sio_enable   = ~busy;
  assign rollover_clr = init_xfer | ~rst_n;
  assign pp_addr      = {{PAD_W{1'b0}}, dev_num, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      init_xfer <= 1'b0;
      pp_wr     <= 1'b0;
      xfer_err  <= 1'b0;
    end else begin
      init_xfer <= 1'b0;
      pp_wr     <= 1'b0;
      xfer_err  <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy      <= 1'b1;
          init_xfer <= 1'b1;
        end
      end else if (req || ack_hit) begin
        busy  <= 1'b0;
        pp_wr <= 1'b1;
      end else if (wd_hit) begin
        busy     <= 1'b0;
        xfer_err <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && req) dev_num <= sr_dev;
    if (busy && (req || ack_hit)) pp_data <= pc_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt  <= '0;
      ack_cnt <= '0;
    end else begin
      wd_cnt  <= (wd_run && !wd_hit && !req) ? wd_cnt + 1'b1 : '0;
      ack_cnt <= (ack_run && !ack_hit && !req) ? ack_cnt + 1'b1 : '0;
    end
  end
endmodule

module chan_ctl_chk #(
  parameter int DEV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             sio_enable,
  input logic             init_xfer,
  input logic             rollover_clr,
  input logic [DEV_W-1:0] dev_num,
  input logic             pp_wr,
  input logic             xfer_err
);
  p_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && sio_enable |=> init_xfer && !sio_enable);
  p_init_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_xfer |=> !init_xfer);
  p_rollclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_xfer |-> rollover_clr);
  p_dev_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sio_enable && !init_xfer |-> $stable(dev_num));
  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req && !sio_enable |=> pp_wr && sio_enable && !xfer_err);
  p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> sio_enable && !pp_wr && !init_xfer);
  p_wb_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pp_wr |-> sio_enable);
endmodule

bind chan_ctl chan_ctl_chk #(.DEV_W(DEV_W)) u_chk (.*);

// File: tb/chan_ctl_tb.sv
module chan_ctl_tb;
  localparam int DEV_W = 8;
  localparam int AW = 16;
  localparam int WD = 20;
  localparam int ACK = 6;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [DEV_W-1:0] sr_dev = '0;
  logic chansr = 1'b0, wait_sr = 1'b0, chanso = 1'b0, chanack = 1'b0;
  logic [AW-1:0] pc_in = '0;
  logic sio_enable, init_xfer, rollover_clr, pp_wr, xfer_err;
  logic [DEV_W-1:0] dev_num;
  logic [AW-1:0] pp_addr, pp_data;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  chan_ctl #(.DEV_W(DEV_W), .AW(AW), .WD_CYC(WD), .ACK_CYC(ACK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .sr_dev(sr_dev), .chansr(chansr),
    .wait_sr(wait_sr), .chanso(chanso), .chanack(chanack), .pc_in(pc_in),
    .sio_enable(sio_enable), .init_xfer(init_xfer), .rollover_clr(rollover_clr),
    .dev_num(dev_num), .pp_wr(pp_wr), .pp_addr(pp_addr), .pp_data(pp_data),
    .xfer_err(xfer_err));

  localparam logic [23:0] VEC [4] = '{
    {8'h05, 16'h1234}, {8'hFF, 16'hFFFF}, {8'h00, 16'h0001}, {8'hA6, 16'h8000}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic claim(input logic [DEV_W-1:0] d);
    sr_dev = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0; sr_dev = ~d;
    chk("R2 enable low", sio_enable, 0);
    chk("R2 init pulse", init_xfer, 1);
    chk("R2 rollover clear", rollover_clr, 1);
    chk("R3 dev capture", dev_num, d);
    @(negedge clk);
    chk("R2 init one cycle", init_xfer, 0);
    chk("R3 dev hold", dev_num, d);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 rollover during reset", rollover_clr, 1);
    chk("R1 enable during reset", sio_enable, 1);
    edges(2); rst_n = 1'b1; @(negedge clk);
    chk("R1 enable", sio_enable, 1);
    chk("R1 pulses", {init_xfer, pp_wr, xfer_err}, 0);

    foreach (VEC[k]) begin
      claim(VEC[k][23:16]);
      edges(3);
      pc_in = VEC[k][15:0]; req = 1'b1;
      @(negedge clk);
      req = 1'b0; pc_in = ~VEC[k][15:0];
      chk("R4 idle", sio_enable, 1);
      chk("R4 pp_wr", pp_wr, 1);
      chk("R4 addr", pp_addr, {6'b0, VEC[k][23:16], 2'b00});
      chk("R4 data", pp_data, VEC[k][15:0]);
      chk("R4 no init/err", {init_xfer, xfer_err}, 0);
      @(negedge clk);
      chk("R4 pulse ends", pp_wr, 0);
    end

    // R5 watchdog expiry
    claim(8'h11); wait_sr = 1'b1;
    edges(WD - 1);
    chk("R5 busy before expiry", sio_enable, 0);
    edges(1);
    chk("R5 idle at expiry", sio_enable, 1);
    chk("R5 err", xfer_err, 1);
    chk("R5 no writeback", pp_wr, 0);
    wait_sr = 1'b0; edges(1);
    chk("R5 err one cycle", xfer_err, 0);

    // R6 chansr restart
    claim(8'h22); wait_sr = 1'b1;
    edges(WD - 2); chansr = 1'b1; edges(1); chansr = 1'b0;
    edges(WD - 1);
    chk("R6 still busy", sio_enable, 0);
    edges(1);
    chk("R6 expiry after restart", xfer_err, 1);
    wait_sr = 1'b0; edges(1);

    // R7 no count without wait
    claim(8'h33);
    edges(WD + 5);
    chk("R7 busy without wait", sio_enable, 0);
    wait_sr = 1'b1; edges(WD - 2); wait_sr = 1'b0; edges(1); wait_sr = 1'b1;
    edges(WD - 1);
    chk("R7 cleared by wait drop", sio_enable, 0);
    edges(1);
    chk("R7 expiry", xfer_err, 1);
    wait_sr = 1'b0; edges(1);

    // R8 ack timeout
    claim(8'h44); pc_in = 16'h0ABC; chanso = 1'b1;
    edges(ACK - 1);
    chk("R8 busy before", sio_enable, 0);
    edges(1);
    chk("R8 idle", sio_enable, 1);
    chk("R8 pp_wr", pp_wr, 1);
    chk("R8 data", pp_data, 16'h0ABC);
    chk("R8 no err", xfer_err, 0);
    chanso = 1'b0; edges(1);

    // R9 ack restart
    claim(8'h55); chanso = 1'b1;
    edges(ACK - 2); chanack = 1'b1; edges(1); chanack = 1'b0;
    edges(ACK - 1);
    chk("R9 busy after ack", sio_enable, 0);
    edges(1);
    chk("R9 expiry after restart", pp_wr, 1);
    chanso = 1'b0; edges(1);

    // R10 req beats watchdog
    claim(8'h66); pc_in = 16'h5A5A; wait_sr = 1'b1;
    edges(WD - 1);
    req = 1'b1; edges(1); req = 1'b0;
    chk("R10 pp_wr wins", pp_wr, 1);
    chk("R10 no err", xfer_err, 0);
    chk("R10 data", pp_data, 16'h5A5A);
    wait_sr = 1'b0; edges(1);

    // R10 ack beats watchdog
    claim(8'h77); wait_sr = 1'b1;
    edges(WD - ACK); chanso = 1'b1;
    edges(ACK);
    chk("R10 ack wins", {pp_wr, xfer_err}, 2'b10);
    chanso = 1'b0; wait_sr = 1'b0; edges(1);

    // R1 reset keeps dev_num
    claim(8'h3C);
    rst_n = 1'b0; edges(1);
    chk("R1 idle in reset", sio_enable, 1);
    chk("R1 dev kept", dev_num, 8'h3C);
    rst_n = 1'b1; edges(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule